// File: doc/BRIEF.md
# Prioritized Interrupt Pending Controller

This block tracks which interrupt sources are waiting on one processor strand. It picks the single source that should be taken next. There is one pending bit per source. Single-cycle raise and retract strobes, each carrying a source index, set and clear these bits. A lower index always wins, so source 0 beats every other source. The order starts with fixed system and error causes, then queue and mondo-style message causes, then interrupt levels 15 down to 1, and ends with error-reporting causes.

Each source is configured on its own through a small write port:
- **Retraction:** automatic (the pending bit clears when the strand accepts the interrupt) or manual (the bit stays set until a retract).
- **Detection:** level or edge. An edge source that has been accepted is held off by a delivered bit until a retract clears it, even though its pending bit is still set.
- **Global gate:** a gate input holds back every delivery, while pending bits keep collecting.

The strand sees a registered valid flag and winner index. It answers with a one-cycle acknowledge, which applies the delivery side effects to the presented source.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, every pending bit and delivered bit is clear. Every source is automatic and level. `sel_vld`, `any_pend` and `cfg_err` are low.
- R2: A raise of index i sets `pend_vec[i]` at the next clock edge. A raise of a source whose bit is already set changes nothing; in particular it does not clear the hold-off of a delivered edge source.
- R3: A retract of index i clears both its pending and delivered bits at the next edge. When a raise and a retract name the same index in one cycle, the retract wins and the bit ends clear.
- R4: `sel_vld`/`sel_idx` are registered. They present the lowest-indexed eligible source, computed from the state written at the same edge. A source raised at edge t is visible right after edge t.
- R5: An acknowledge while `sel_vld` is high, for an automatic source, clears that source's pending bit. Selection moves to the next eligible source at the same edge.
- R6: For a manual level source, an acknowledge leaves the pending bit set, and the source stays selected.
- R7: For a manual edge source, an acknowledge sets its delivered bit. The source is then not selected while it stays pending, until a retract. After a retract and a new raise it is selected again.
- R8: A configuration write with `cfg_edge`=1 and `cfg_manual`=0 is refused. `cfg_err` is high for exactly the one cycle after it, and the source's previous setting is kept.
- R9: While `gate_off` is high, `sel_vld` is low after the next edge, and raises still set pending bits. Once the gate drops, the winner appears after the next edge.
- R10: `any_pend` is high exactly when at least one bit of `pend_vec` is set.
- R11: An acknowledge while `sel_vld` is low changes no pending or delivered bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Raise strobe |
| raise_idx | input | IDX_W | Source index to raise |
| retract_vld | input | 1 | Retract strobe |
| retract_idx | input | IDX_W | Source index to retract |
| cfg_vld | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source being configured |
| cfg_manual | input | 1 | 1 = manual retraction, 0 = automatic |
| cfg_edge | input | 1 | 1 = edge detection, 0 = level |
| gate_off | input | 1 | Global delivery block |
| ack | input | 1 | Strand accepts the presented source |
| sel_vld | output | 1 | A source is presented |
| sel_idx | output | IDX_W | Index of the presented source |
| any_pend | output | 1 | At least one source is pending |
| pend_vec | output | NUM_SRC | Per-source pending status |
| cfg_err | output | 1 | Refused configuration write (one cycle) |

## Verification
The hardest condition to reach is an edge source that is still pending but held off by its delivered bit. A plain pending check cannot tell this state apart from a normal pending source. The stimulus configures a source as manual edge, raises it, and acknowledges it. It then shows that `pend_vec` still reports the bit while `sel_vld` stays low, even after a second raise. Only a retract followed by a fresh raise brings the source back to the selector.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    localparam int unsigned IRQ_NSRC_DEF  = 33;
    localparam int unsigned IRQ_IDX_W_DEF = $clog2(IRQ_NSRC_DEF);

    typedef enum logic {
        RET_AUTO   = 1'b0,
        RET_MANUAL = 1'b1
    } ret_mode_e;

    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_EDGE  = 1'b1
    } det_mode_e;
endpackage

// File: rtl/irq_idx_dec.sv
module irq_idx_dec #(
    parameter int unsigned N = 33,
    parameter int unsigned W = 6
) (
    input  logic         en,
    input  logic [W-1:0] idx,
    output logic [N-1:0] onehot
);
    for (genvar g = 0; g < N; g++) begin : g_line
        assign onehot[g] = en && (idx == W'(g));
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N = 33,
    parameter int unsigned W = 6
) (
    input  logic [N-1:0] req,
    output logic         vld,
    output logic [W-1:0] idx
);
    always_comb begin
        vld = 1'b0;
        idx = '0;
        // scan from the top down so the lowest set index is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int unsigned NUM_SRC = IRQ_NSRC_DEF,
    parameter int unsigned IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_vld,
    input  logic [IDX_W-1:0]   raise_idx,
    input  logic               retract_vld,
    input  logic [IDX_W-1:0]   retract_idx,
    input  logic               cfg_vld,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic               cfg_manual,
    input  logic               cfg_edge,
    input  logic               gate_off,
    input  logic               ack,
    output logic               sel_vld,
    output logic [IDX_W-1:0]   sel_idx,
    output logic               any_pend,
    output logic [NUM_SRC-1:0] pend_vec,
    output logic               cfg_err
);
    typedef struct packed {
        logic [NUM_SRC-1:0] pending;
        logic [NUM_SRC-1:0] delivered;
        logic [NUM_SRC-1:0] manual;
        logic [NUM_SRC-1:0] edge_det;
        logic               sel_vld;
        logic [IDX_W-1:0]   sel_idx;
        logic               cfg_err;
    } state_t;

    state_t st_d, st_q;

    logic               cfg_bad;
    logic               cfg_ok;
    logic [NUM_SRC-1:0] raise_oh, retract_oh, cfg_oh, ack_oh;
    logic [NUM_SRC-1:0] eligible;
    logic               enc_vld;
    logic [IDX_W-1:0]   enc_idx;

    assign cfg_bad = cfg_vld && cfg_edge && (cfg_manual == RET_AUTO);
    assign cfg_ok  = cfg_vld && !cfg_bad;

    irq_idx_dec #(.N(NUM_SRC), .W(IDX_W)) u_dec_raise (
        .en(raise_vld), .idx(raise_idx), .onehot(raise_oh));
    irq_idx_dec #(.N(NUM_SRC), .W(IDX_W)) u_dec_retract (
        .en(retract_vld), .idx(retract_idx), .onehot(retract_oh));
    irq_idx_dec #(.N(NUM_SRC), .W(IDX_W)) u_dec_cfg (
        .en(cfg_ok), .idx(cfg_idx), .onehot(cfg_oh));
    irq_idx_dec #(.N(NUM_SRC), .W(IDX_W)) u_dec_ack (
        .en(ack && st_q.sel_vld), .idx(st_q.sel_idx), .onehot(ack_oh));

    irq_prio_enc #(.N(NUM_SRC), .W(IDX_W)) u_enc (
        .req(eligible), .vld(enc_vld), .idx(enc_idx));

    always_comb begin
        st_d = st_q;

        // delivery side effects for the presented source
        st_d.pending   = st_d.pending & ~(ack_oh & st_q.pending & ~st_q.manual);
        st_d.delivered = st_d.delivered | (ack_oh & st_q.pending & st_q.edge_det);

        // raise only touches sources that are not already pending
        st_d.pending   = st_d.pending | (raise_oh & ~st_q.pending);

        // retract has the last word
        st_d.pending   = st_d.pending   & ~retract_oh;
        st_d.delivered = st_d.delivered & ~retract_oh;

        // configuration
        st_d.manual   = (st_q.manual   & ~cfg_oh) | (cfg_manual ? cfg_oh : '0);
        st_d.edge_det = (st_q.edge_det & ~cfg_oh) | (cfg_edge   ? cfg_oh : '0);
        st_d.cfg_err  = cfg_bad;

        // selection over the state being written this edge
        eligible = st_d.pending & ~(st_d.delivered & st_d.edge_det)
                 & {NUM_SRC{!gate_off}};
        st_d.sel_vld = enc_vld;
        st_d.sel_idx = enc_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_vld  = st_q.sel_vld;
    assign sel_idx  = st_q.sel_idx;
    assign pend_vec = st_q.pending;
    assign any_pend = |st_q.pending;
    assign cfg_err  = st_q.cfg_err;
endmodule

// File: rtl/irq_pend_chk.sv
module irq_pend_chk #(
    parameter int unsigned NUM_SRC = 33,
    parameter int unsigned IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               raise_vld,
    input logic [IDX_W-1:0]   raise_idx,
    input logic               retract_vld,
    input logic [IDX_W-1:0]   retract_idx,
    input logic               cfg_vld,
    input logic               cfg_manual,
    input logic               cfg_edge,
    input logic               gate_off,
    input logic               sel_vld,
    input logic [IDX_W-1:0]   sel_idx,
    input logic               any_pend,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic               cfg_err
);
    // R3: a retract leaves the named bit clear
    p_retract_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        retract_vld && (retract_idx < IDX_W'(NUM_SRC))
        |=> !pend_vec[$past(retract_idx)]);

    // R2: a raise not cancelled by a retract leaves the bit set
    p_raise_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        raise_vld && (raise_idx < IDX_W'(NUM_SRC)) && !pend_vec[raise_idx]
        && !(retract_vld && retract_idx == raise_idx)
        |=> pend_vec[$past(raise_idx)]);

    // R9: the gate holds back every delivery
    p_gate_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gate_off |=> !sel_vld);

    // R8: a refused configuration write is flagged
    p_cfg_refused_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_vld && cfg_edge && !cfg_manual |=> cfg_err);

    // R4: a presented source is always pending
    p_sel_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld |-> pend_vec[sel_idx]);

    // R10: summary flag tracks the vector
    p_any_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend == ($countones(pend_vec) != 0));
endmodule

bind irq_pend_ctrl irq_pend_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .raise_vld(raise_vld), .raise_idx(raise_idx),
    .retract_vld(retract_vld), .retract_idx(retract_idx),
    .cfg_vld(cfg_vld), .cfg_manual(cfg_manual), .cfg_edge(cfg_edge),
    .gate_off(gate_off), .sel_vld(sel_vld), .sel_idx(sel_idx),
    .any_pend(any_pend), .pend_vec(pend_vec), .cfg_err(cfg_err));

// File: tb/tb_irq_pend_ctrl.sv
`timescale 1ns/100ps
module tb_irq_pend_ctrl;
    localparam int unsigned N = 33;
    localparam int unsigned W = $clog2(N);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         raise_vld = 1'b0, retract_vld = 1'b0, cfg_vld = 1'b0;
    logic [W-1:0] raise_idx = '0, retract_idx = '0, cfg_idx = '0;
    logic         cfg_manual = 1'b0, cfg_edge = 1'b0, gate_off = 1'b0, ack = 1'b0;
    logic         sel_vld, any_pend, cfg_err;
    logic [W-1:0] sel_idx;
    logic [N-1:0] pend_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_pend_ctrl #(.NUM_SRC(N), .IDX_W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_idx(raise_idx),
        .retract_vld(retract_vld), .retract_idx(retract_idx),
        .cfg_vld(cfg_vld), .cfg_idx(cfg_idx),
        .cfg_manual(cfg_manual), .cfg_edge(cfg_edge),
        .gate_off(gate_off), .ack(ack),
        .sel_vld(sel_vld), .sel_idx(sel_idx),
        .any_pend(any_pend), .pend_vec(pend_vec), .cfg_err(cfg_err));

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_sel(input string req, input bit v, input int i);
        chk(req, "sel_vld", sel_vld, v);
        if (v) chk(req, "sel_idx", sel_idx, i);
    endtask

    task automatic do_raise(input int i);
        raise_vld = 1'b1; raise_idx = W'(i);
        tick();
        raise_vld = 1'b0;
    endtask

    task automatic do_retract(input int i);
        retract_vld = 1'b1; retract_idx = W'(i);
        tick();
        retract_vld = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1;
        tick();
        ack = 1'b0;
    endtask

    task automatic do_cfg(input int i, input bit man, input bit edg);
        cfg_vld = 1'b1; cfg_idx = W'(i); cfg_manual = man; cfg_edge = edg;
        tick();
        cfg_vld = 1'b0; cfg_manual = 1'b0; cfg_edge = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "pend_vec", longint'(pend_vec), 0);
        chk("R1", "sel_vld", sel_vld, 0);
        chk("R1", "any_pend", any_pend, 0);
        chk("R1", "cfg_err", cfg_err, 0);
        chk("R10", "any_pend idle", any_pend, 0);
    endtask

    task automatic t_priority();
        do_raise(20);
        chk("R2", "pend 20", pend_vec[20], 1);
        chk_sel("R4", 1, 20);
        chk("R10", "any_pend", any_pend, 1);
        do_raise(5);
        chk_sel("R4", 1, 5);
        do_raise(32);
        chk_sel("R4", 1, 5);
        do_ack();
        chk("R5", "pend 5 cleared", pend_vec[5], 0);
        chk_sel("R5", 1, 20);
        do_ack();
        chk_sel("R5", 1, 32);
        do_ack();
        chk_sel("R5", 0, 0);
        chk("R10", "any_pend empty", any_pend, 0);
    endtask

    task automatic t_manual_level();
        do_cfg(3, 1'b1, 1'b0);
        do_raise(3);
        do_ack();
        chk("R6", "pend 3 kept", pend_vec[3], 1);
        chk_sel("R6", 1, 3);
        do_ack();
        chk_sel("R6", 1, 3);
        do_retract(3);
        chk("R3", "pend 3 retracted", pend_vec[3], 0);
        chk_sel("R3", 0, 0);
    endtask

    task automatic t_edge();
        do_cfg(7, 1'b1, 1'b1);
        chk("R8", "legal cfg no err", cfg_err, 0);
        do_raise(7);
        chk_sel("R7", 1, 7);
        do_ack();
        chk("R7", "pend 7 kept", pend_vec[7], 1);
        chk_sel("R7", 0, 0);
        do_raise(7);
        chk_sel("R2", 0, 0);
        chk("R2", "pend 7 still", pend_vec[7], 1);
        do_retract(7);
        chk("R3", "pend 7 cleared", pend_vec[7], 0);
        do_raise(7);
        chk_sel("R7", 1, 7);
        do_retract(7);
        do_cfg(7, 1'b0, 1'b0);
    endtask

    task automatic t_cfg_err();
        do_cfg(9, 1'b0, 1'b1);
        chk("R8", "cfg_err high", cfg_err, 1);
        tick();
        chk("R8", "cfg_err one cycle", cfg_err, 0);
        do_raise(9);
        do_ack();
        chk("R8", "source 9 still auto", pend_vec[9], 0);
        chk_sel("R8", 0, 0);
    endtask

    task automatic t_gate();
        gate_off = 1'b1;
        do_raise(30);
        do_raise(12);
        chk_sel("R9", 0, 0);
        chk("R9", "pend 12", pend_vec[12], 1);
        chk("R9", "pend 30", pend_vec[30], 1);
        do_ack();
        chk("R11", "pend 12 after idle ack", pend_vec[12], 1);
        chk("R11", "pend 30 after idle ack", pend_vec[30], 1);
        gate_off = 1'b0;
        tick();
        chk_sel("R9", 1, 12);
        do_ack();
        do_ack();
        chk("R5", "gate drained", longint'(pend_vec), 0);
    endtask

    task automatic t_retract_race();
        raise_vld = 1'b1; raise_idx = W'(15);
        retract_vld = 1'b1; retract_idx = W'(15);
        tick();
        raise_vld = 1'b0; retract_vld = 1'b0;
        chk("R3", "retract beats raise", pend_vec[15], 0);
        do_raise(2);
        do_raise(4);
        chk_sel("R4", 1, 2);
        do_retract(2);
        chk_sel("R3", 1, 4);
        do_retract(4);
        chk("R10", "any_pend after cleanup", any_pend, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_priority();
        t_manual_level();
        t_edge();
        t_cfg_err();
        t_gate();
        t_retract_race();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule